// File: doc/BRIEF.md
# Bus Idle-Time Gate for a Single-Wire Control Bus

This block tells a transmit engine when it may begin driving the start bit of a message on a shared single-wire control bus. It measures how long the line has stayed high after an arming event, counting in half-bit-period ticks supplied by a bit-timing generator. Once the programmed idle time has passed, it raises `bus_free`. The transmit engine then starts the start bit and acknowledges with `start_ack`.

The wait is chosen by a 3-bit setting. A nonzero setting n requests n − 0.5 bit periods. A zero setting selects a protocol default: 5 bit periods after this node's own successful send, 7 bit periods for a node that is taking over as a new initiator, and 3 bit periods before a retry. A start-option input decides what arms the measurement. It is either the software start-of-message request, or the end-of-message pulse from the transmitter or receiver. A low level on the line at any time discards the idle time gathered so far.

Top module: `sft_bus_gate`

## Requirements
- R1: After reset `bus_free` is low and the block is disarmed, so half-bit ticks on a high line do not raise `bus_free` until an arming event.
- R2: With `sft_sel` = n (1..7), `bus_free` rises on the clock edge that samples the (2n − 1)th `half_tick` after arming, provided the line stayed high; it is still low after 2n − 2 ticks.
- R3: With `sft_sel` = 0, the number of ticks comes from `dflt_kind`: 0 (own send done) = 10 ticks, 1 (new initiator) = 14 ticks, 2 (retry) = 6 ticks, 3 behaves like 1.
- R4: With `auto_start` = 0, only `sof_req` arms the measurement, and `msg_end` has no effect.
- R5: With `auto_start` = 1, only `msg_end` arms the measurement, and `sof_req` has no effect.
- R6: A low `line_hi` in any cycle zeroes the idle count and drives `bus_free` low at the next edge. The block stays armed, so the full wait starts again once the line is high.
- R7: Once high, `bus_free` stays high across further ticks and idle cycles until `start_ack`, a low line or a new arming event.
- R8: `start_ack` drives `bus_free` low at the next edge and disarms the block. Later ticks do not raise `bus_free` again until the block is re-armed.
- R9: An arming pulse restarts the count from zero, and a `half_tick` in the same cycle as the arming pulse is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sft_sel | input | 3 | Idle-time setting; 0 selects the default |
| dflt_kind | input | 2 | Default-wait selector used when `sft_sel` = 0 |
| auto_start | input | 1 | 0: arm on `sof_req`; 1: arm on `msg_end` |
| half_tick | input | 1 | One-cycle pulse every half nominal bit period |
| line_hi | input | 1 | Sampled bus level, 1 = released/high |
| sof_req | input | 1 | Start-of-message request pulse |
| msg_end | input | 1 | End of transmitted or received message pulse |
| start_ack | input | 1 | Transmit engine has begun the start bit |
| bus_free | output | 1 | Idle time met; transmitter may start |

## Verification
The idle count is exercised with every nonzero setting and with all four default selectors, under both start options, and with random mixes of these. Each case checks that `bus_free` is still low one tick short of the target and high exactly at the target, which separates an off-by-one count from a correct one. Directed cases pull the line low part-way through a wait and while `bus_free` is high. Others send the arming pulse that belongs to the other start option, send ticks after an acknowledge, and apply reset mid-count. Together these separate a count that restarts on a low line from one that only pauses, and a disarm on acknowledge from a plain clear of the output.

// File: rtl/sft_bus_gate.sv
module sft_bus_gate #(
  parameter int SEL_W           = 3,
  parameter int DFLT_OWN_BITS   = 5,
  parameter int DFLT_NEW_BITS   = 7,
  parameter int DFLT_RETRY_BITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sft_sel,
  input  logic [1:0]       dflt_kind,
  input  logic             auto_start,
  input  logic             half_tick,
  input  logic             line_hi,
  input  logic             sof_req,
  input  logic             msg_end,
  input  logic             start_ack,
  output logic             bus_free
);
  localparam int SEL_TICKS_MAX = 2 * ((1 << SEL_W) - 1) - 1;
  localparam int DFLT_MAX_BITS = (DFLT_NEW_BITS > DFLT_OWN_BITS)
                               ? ((DFLT_NEW_BITS > DFLT_RETRY_BITS) ? DFLT_NEW_BITS : DFLT_RETRY_BITS)
                               : ((DFLT_OWN_BITS > DFLT_RETRY_BITS) ? DFLT_OWN_BITS : DFLT_RETRY_BITS);
  localparam int TICKS_MAX = (2 * DFLT_MAX_BITS > SEL_TICKS_MAX) ? 2 * DFLT_MAX_BITS : SEL_TICKS_MAX;
  localparam int CNT_W     = $clog2(TICKS_MAX + 1);

  logic [CNT_W-1:0] cnt, cnt_nx, target;
  logic             armed, arm_evt, restart;

  assign arm_evt = auto_start ? msg_end : sof_req;
  assign restart = !line_hi || start_ack || arm_evt;
  assign cnt_nx  = cnt + 1'b1;

  always_comb begin
    if (sft_sel != '0) begin
      target = CNT_W'((2 * int'(sft_sel)) - 1);
    end else begin
      unique case (dflt_kind)
        2'd0:    target = CNT_W'(2 * DFLT_OWN_BITS);
        2'd2:    target = CNT_W'(2 * DFLT_RETRY_BITS);
        default: target = CNT_W'(2 * DFLT_NEW_BITS);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (start_ack)  armed <= 1'b0;
    else if (arm_evt)    armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      bus_free <= 1'b0;
    end else if (restart) begin
      cnt      <= '0;
      bus_free <= 1'b0;
    end else if (armed && half_tick && !bus_free) begin
      cnt      <= cnt_nx;
      bus_free <= (cnt_nx >= target);
    end
  end
endmodule

// File: rtl/sft_bus_gate_chk.sv
module sft_bus_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic auto_start,
  input logic half_tick,
  input logic line_hi,
  input logic sof_req,
  input logic msg_end,
  input logic start_ack,
  input logic bus_free
);
  logic arm_seen;
  assign arm_seen = auto_start ? msg_end : sof_req;

  p_low_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_hi |=> !bus_free);

  p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_ack |=> !bus_free);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && line_hi && !start_ack && !arm_seen) |=> bus_free);

  p_rise_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> ($past(half_tick) && $past(line_hi) && !$past(arm_seen)));

  p_no_rise_on_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arm_seen |=> !bus_free);
endmodule

bind sft_bus_gate sft_bus_gate_chk i_chk (
  .clk(clk), .rst_n(rst_n), .auto_start(auto_start), .half_tick(half_tick),
  .line_hi(line_hi), .sof_req(sof_req), .msg_end(msg_end),
  .start_ack(start_ack), .bus_free(bus_free)
);

// File: tb/test_sft_bus_gate.sv
`timescale 1ns/1ps
module test_sft_bus_gate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sft_sel = 3'd0;
  logic [1:0] dflt_kind = 2'd0;
  logic       auto_start = 1'b0;
  logic       half_tick = 1'b0;
  logic       line_hi = 1'b1;
  logic       sof_req = 1'b0;
  logic       msg_end = 1'b0;
  logic       start_ack = 1'b0;
  logic       bus_free;
  int         checks = 0;
  int         errors = 0;
  int         cycles = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sft_bus_gate i_sft_bus_gate (
    .clk(clk), .rst_n(rst_n), .sft_sel(sft_sel), .dflt_kind(dflt_kind),
    .auto_start(auto_start), .half_tick(half_tick), .line_hi(line_hi),
    .sof_req(sof_req), .msg_end(msg_end), .start_ack(start_ack),
    .bus_free(bus_free)
  );

  function automatic int exp_ticks(input logic [2:0] sel, input logic [1:0] kind);
    if (sel != 0) return 2 * int'(sel) - 1;
    case (kind)
      2'd0:    return 10;
      2'd2:    return 6;
      default: return 14;
    endcase
  endfunction

  task automatic chk(input string req, input logic exp);
    checks++;
    if (bus_free !== exp) begin
      errors++;
      $display("FAIL %s: bus_free=%b expected=%b at %0t", req, bus_free, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic tick();
    half_tick = 1'b1; cyc(); half_tick = 1'b0; cyc();
  endtask

  task automatic arm();
    if (auto_start) msg_end = 1'b1; else sof_req = 1'b1;
    half_tick = 1'b1;
    cyc();
    msg_end = 1'b0; sof_req = 1'b0; half_tick = 1'b0;
    cyc();
  endtask

  task automatic ack();
    start_ack = 1'b1; cyc(); start_ack = 1'b0;
  endtask

  task automatic run_case(input logic [2:0] sel, input logic [1:0] kind, input logic mode);
    int t;
    string req;
    sft_sel = sel; dflt_kind = kind; auto_start = mode;
    t = exp_ticks(sel, kind);
    req = (sel == 0) ? "R3" : "R2";
    arm();
    chk("R9 arm-cycle tick ignored", 1'b0);
    for (int i = 0; i < t - 1; i++) tick();
    chk({req, " one tick short"}, 1'b0);
    tick();
    chk({req, mode ? " R5 auto arm" : " R4 request arm"}, 1'b1);
    tick(); cyc();
    chk("R7 hold", 1'b1);
    ack();
    chk("R8 ack clears", 1'b0);
    for (int i = 0; i < t; i++) tick();
    chk("R8 disarmed after ack", 1'b0);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) cyc();
    chk("R1 in reset", 1'b0);
    rst_n = 1'b1;
    cyc();
    sft_sel = 3'd1;
    for (int i = 0; i < 4; i++) tick();
    chk("R1 disarmed after reset", 1'b0);

    for (int s = 1; s < 8; s++) run_case(3'(s), 2'd0, 1'b0);
    for (int k = 0; k < 4; k++) run_case(3'd0, 2'(k), 1'b1);

    // R6 low line part-way through wait restarts full count
    sft_sel = 3'd3; auto_start = 1'b0;
    arm();
    for (int i = 0; i < 3; i++) tick();
    line_hi = 1'b0; cyc(); line_hi = 1'b1;
    chk("R6 low mid-wait", 1'b0);
    for (int i = 0; i < 4; i++) tick();
    chk("R6 count restarted (4 of 5)", 1'b0);
    tick();
    chk("R6 full wait after restart", 1'b1);
    line_hi = 1'b0; cyc();
    chk("R6 low clears bus_free", 1'b0);
    line_hi = 1'b1;
    for (int i = 0; i < 5; i++) tick();
    chk("R6 stays armed after low", 1'b1);
    ack();

    // R4 msg_end ignored in request mode
    auto_start = 1'b0; sft_sel = 3'd2;
    msg_end = 1'b1; cyc(); msg_end = 1'b0;
    for (int i = 0; i < 6; i++) tick();
    chk("R4 msg_end ignored", 1'b0);
    // R5 sof_req ignored in auto mode
    auto_start = 1'b1;
    sof_req = 1'b1; cyc(); sof_req = 1'b0;
    for (int i = 0; i < 6; i++) tick();
    chk("R5 sof_req ignored", 1'b0);

    // R9 re-arm restarts count
    auto_start = 1'b0; sft_sel = 3'd2;
    arm(); tick(); tick();
    arm();
    tick(); tick();
    chk("R9 re-arm restarts", 1'b0);
    tick();
    chk("R9 target after re-arm", 1'b1);

    // R1 reset mid-state
    rst_n = 1'b0; cyc();
    chk("R1 reset clears", 1'b0);
    rst_n = 1'b1; cyc();
    for (int i = 0; i < 4; i++) tick();
    chk("R1 disarmed by reset", 1'b0);

    for (int n = 0; n < 30; n++) begin
      run_case(3'($urandom_range(0, 7)), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule